// File: doc/BRIEF.md
# Notification-Driven Session Receive Client

This block sits on the application side of a session-based transport engine and drains received payload from it. The engine sends notification records. Each record carries a session identifier, a byte count, the peer's address and port, and a flag that marks the session as closed. When a record reports new data, the client sends a read request for that session and byte count. It then accepts a metadata word that names the session being served. After that it passes the matching stream burst (data, byte keep, last) to a local sink, and every beat it forwards carries the session tag.

A record with the closed flag set does not lead to any read. It produces a single-cycle close event on a separate output. A data record with a byte count of zero is discarded. Only one read is in flight at any time. The client checks each burst it forwards against the byte count it requested and raises a sticky error flag when the two differ. Every channel uses a valid/ready handshake, and any side may apply backpressure.

Top module: `rxClient`

## Requirements
- R1: After reset, ntfReady is 1, and reqValid, metaReady, rxReady, outValid, closeValid and errSticky are all 0.
- R2: A notification accepted with ntfClosed=0 and ntfLength!=0 produces reqValid=1 in the next cycle, with reqSession and reqLength equal to the notification's session and length. The request holds stable until a cycle in which reqReady=1.
- R3: A notification accepted with ntfClosed=1, at any length, issues no request. closeValid is 1 for exactly the one cycle after acceptance, and closeSession holds the notification's session.
- R4: A notification accepted with ntfClosed=0 and ntfLength=0 is dropped. It produces no request and no close event, and ntfReady stays 1.
- R5: From the acceptance of a data notification until the handshake on the beat that carries rxLast=1, ntfReady is 0. It returns to 1 in the cycle after that beat.
- R6: metaReady is 1 only after the request handshake and before the metadata handshake. The accepted metaSession appears on outSession for every beat of the burst that follows.
- R7: During the data phase, outValid equals rxValid, rxReady equals outReady, and outData, outKeep and outLast equal rxData, rxKeep and rxLast. Outside the data phase, outValid and rxReady are 0.
- R8: The bytes of a burst are counted as the total number of set keep bits over all its handshaken beats. If that total differs from the requested length at the last beat, errSticky becomes 1 and stays 1 until reset.
- R9: ntfPeerAddr and ntfPeerPort have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ntfValid | input | 1 | Notification valid |
| ntfReady | output | 1 | Notification ready |
| ntfSession | input | 16 | Notification session ID |
| ntfLength | input | 16 | Notification byte count |
| ntfPeerAddr | input | 32 | Peer IP address (informational) |
| ntfPeerPort | input | 16 | Peer port (informational) |
| ntfClosed | input | 1 | Session closed flag |
| reqValid | output | 1 | Read request valid |
| reqReady | input | 1 | Read request ready |
| reqSession | output | 16 | Requested session ID |
| reqLength | output | 16 | Requested byte count |
| metaValid | input | 1 | Response metadata valid |
| metaReady | output | 1 | Response metadata ready |
| metaSession | input | 16 | Session served by the response |
| rxValid | input | 1 | Response data valid |
| rxReady | output | 1 | Response data ready |
| rxData | input | DATA_W | Response data |
| rxKeep | input | DATA_W/8 | Response byte keep |
| rxLast | input | 1 | Last response beat |
| outValid | output | 1 | Sink data valid |
| outReady | input | 1 | Sink ready |
| outData | output | DATA_W | Forwarded data |
| outKeep | output | DATA_W/8 | Forwarded keep |
| outLast | output | 1 | Forwarded last |
| outSession | output | 16 | Session tag of the forwarded beat |
| closeValid | output | 1 | One-cycle close event |
| closeSession | output | 16 | Session of the close event |
| errSticky | output | 1 | Sticky byte-count mismatch flag |

## Verification
Several properties are checked by assertions on every cycle. Only one channel is open at any time. A request under backpressure holds its contents. No request ever carries a length of zero. Every close event traces back to an accepted closed notification. The error flag never clears once it is set. The bench is needed to show the arithmetic: the keep-bit byte totals across sweeps of length and backpressure pattern. It also shows that zero-length and closed records are filtered, that the session tag reaches each beat, and that a mismatched burst trips the error flag.

// File: rtl/rxClientPkg.sv
package rxClientPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_META = 2'd2,
    ST_DATA = 2'd3
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptData;
    logic acceptClose;
    logic acceptMeta;
    logic beatFire;
    logic lastFire;
  } ctrlStrobe_t;
endpackage

// File: rtl/rxClientCtrl.sv
module rxClientCtrl
  import rxClientPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ntfValid,
  input  logic        ntfClosed,
  input  logic        ntfZero,
  input  logic        reqReady,
  input  logic        metaValid,
  input  logic        rxValid,
  input  logic        rxLast,
  input  logic        outReady,
  output logic        ntfReady,
  output logic        reqValid,
  output logic        metaReady,
  output logic        rxReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);
  rxState_e state, stateNext;

  always_comb begin
    ntfReady  = (state == ST_IDLE);
    reqValid  = (state == ST_REQ);
    metaReady = (state == ST_META);
    rxReady   = (state == ST_DATA) && outReady;
    outValid  = (state == ST_DATA) && rxValid;

    strobe.acceptData  = ntfValid && ntfReady && !ntfClosed && !ntfZero;
    strobe.acceptClose = ntfValid && ntfReady && ntfClosed;
    strobe.acceptMeta  = metaValid && metaReady;
    strobe.beatFire    = outValid && outReady;
    strobe.lastFire    = strobe.beatFire && rxLast;

    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobe.acceptData) stateNext = ST_REQ;
      ST_REQ:  if (reqReady) stateNext = ST_META;
      ST_META: if (strobe.acceptMeta) stateNext = ST_DATA;
      ST_DATA: if (strobe.lastFire) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R5 R6 R7: at most one channel of the transaction is open at once
  assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (!rstN)
    ntfReady |-> (!reqValid && !metaReady && !rxReady && !outValid));

  // R2: a pending request is not withdrawn
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid);

  // R6: metadata is taken only right after a request handshake or while waiting
  assert_meta_after_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(metaReady) |-> $past(reqValid && reqReady));
endmodule

// File: rtl/rxClientDatapath.sv
module rxClientDatapath
  import rxClientPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SID_W  = 16,
  parameter int LEN_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [SID_W-1:0]    ntfSession,
  input  logic [LEN_W-1:0]    ntfLength,
  input  logic [SID_W-1:0]    metaSession,
  input  logic [DATA_W/8-1:0] rxKeep,
  output logic [SID_W-1:0]    reqSession,
  output logic [LEN_W-1:0]    reqLength,
  output logic [SID_W-1:0]    tagSession,
  output logic                closeValid,
  output logic [SID_W-1:0]    closeSession,
  output logic                errSticky
);
  localparam int KEEP_W = DATA_W / 8;
  localparam int POP_W  = $clog2(KEEP_W + 1);
  localparam int CNT_W  = LEN_W + 1;

  function automatic logic [POP_W-1:0] keepBytes(input logic [KEEP_W-1:0] k);
    logic [POP_W-1:0] n;
    n = '0;
    for (int i = 0; i < KEEP_W; i++) n = n + POP_W'(k[i]);
    return n;
  endfunction

  logic [CNT_W-1:0] byteCount;
  logic [CNT_W-1:0] byteSum;

  assign byteSum = byteCount + CNT_W'(keepBytes(rxKeep));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqSession   <= '0;
      reqLength    <= '0;
      tagSession   <= '0;
      closeValid   <= 1'b0;
      closeSession <= '0;
      byteCount    <= '0;
      errSticky    <= 1'b0;
    end else begin
      closeValid <= strobe.acceptClose;
      if (strobe.acceptClose) closeSession <= ntfSession;
      if (strobe.acceptData) begin
        reqSession <= ntfSession;
        reqLength  <= ntfLength;
        byteCount  <= '0;
      end
      if (strobe.acceptMeta) tagSession <= metaSession;
      if (strobe.beatFire) byteCount <= byteSum;
      if (strobe.lastFire && (byteSum != CNT_W'(reqLength))) errSticky <= 1'b1;
    end
  end

  // R8: the error flag never clears outside reset
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(errSticky) |-> errSticky);
endmodule

// File: rtl/rxClient.sv
module rxClient
  import rxClientPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ntfValid,
  output logic                ntfReady,
  input  logic [15:0]         ntfSession,
  input  logic [15:0]         ntfLength,
  input  logic [31:0]         ntfPeerAddr,
  input  logic [15:0]         ntfPeerPort,
  input  logic                ntfClosed,
  output logic                reqValid,
  input  logic                reqReady,
  output logic [15:0]         reqSession,
  output logic [15:0]         reqLength,
  input  logic                metaValid,
  output logic                metaReady,
  input  logic [15:0]         metaSession,
  input  logic                rxValid,
  output logic                rxReady,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [DATA_W/8-1:0] rxKeep,
  input  logic                rxLast,
  output logic                outValid,
  input  logic                outReady,
  output logic [DATA_W-1:0]   outData,
  output logic [DATA_W/8-1:0] outKeep,
  output logic                outLast,
  output logic [15:0]         outSession,
  output logic                closeValid,
  output logic [15:0]         closeSession,
  output logic                errSticky
);
  ctrlStrobe_t strobe;
  logic        peerUnused;

  // peer identity is informational only (R9)
  assign peerUnused = ^{ntfPeerAddr, ntfPeerPort};

  rxClientCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .ntfValid(ntfValid), .ntfClosed(ntfClosed), .ntfZero(ntfLength == 16'd0),
    .reqReady(reqReady), .metaValid(metaValid), .rxValid(rxValid),
    .rxLast(rxLast), .outReady(outReady),
    .ntfReady(ntfReady), .reqValid(reqValid), .metaReady(metaReady),
    .rxReady(rxReady), .outValid(outValid), .strobe(strobe)
  );

  rxClientDatapath #(.DATA_W(DATA_W), .SID_W(16), .LEN_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ntfSession(ntfSession), .ntfLength(ntfLength),
    .metaSession(metaSession), .rxKeep(rxKeep),
    .reqSession(reqSession), .reqLength(reqLength), .tagSession(outSession),
    .closeValid(closeValid), .closeSession(closeSession), .errSticky(errSticky)
  );

  assign outData = rxData;
  assign outKeep = rxKeep;
  assign outLast = rxLast;

  // R2 R4: no request ever asks for zero bytes
  assert_no_empty_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqLength != 16'd0));

  // R2: request contents stay put under backpressure
  assert_req_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> ($stable(reqSession) && $stable(reqLength)));

  // R3: each close event follows an accepted closed notification
  assert_close_origin_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(closeValid) |-> $past(ntfValid && ntfReady && ntfClosed));
endmodule

// File: tb/rxClient_bench.sv
module rxClient_bench;
  localparam int DW = 64;
  localparam int KW = DW / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic ntfValid = 0, ntfClosed = 0;
  logic [15:0] ntfSession = 0, ntfLength = 0, ntfPeerPort = 0;
  logic [31:0] ntfPeerAddr = 0;
  logic reqReady = 0, metaValid = 0, rxValid = 0, rxLast = 0, outReady = 0;
  logic [15:0] metaSession = 0;
  logic [DW-1:0] rxData = 0;
  logic [KW-1:0] rxKeep = 0;
  logic ntfReady, reqValid, metaReady, rxReady, outValid, outLast;
  logic closeValid, errSticky;
  logic [15:0] reqSession, reqLength, outSession, closeSession;
  logic [DW-1:0] outData;
  logic [KW-1:0] outKeep;

  rxClient #(.DATA_W(DW)) u_rxClient (
    .clk(clk), .rstN(rstN),
    .ntfValid(ntfValid), .ntfReady(ntfReady), .ntfSession(ntfSession),
    .ntfLength(ntfLength), .ntfPeerAddr(ntfPeerAddr), .ntfPeerPort(ntfPeerPort),
    .ntfClosed(ntfClosed),
    .reqValid(reqValid), .reqReady(reqReady), .reqSession(reqSession), .reqLength(reqLength),
    .metaValid(metaValid), .metaReady(metaReady), .metaSession(metaSession),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData), .rxKeep(rxKeep), .rxLast(rxLast),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outKeep(outKeep),
    .outLast(outLast), .outSession(outSession),
    .closeValid(closeValid), .closeSession(closeSession), .errSticky(errSticky)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  // offer a notification; returns at the negedge after acceptance
  task automatic offerNtf(input logic [15:0] sid, input logic [15:0] len, input logic cl,
                          input logic [31:0] addr, input logic [15:0] port);
    @(negedge clk);
    while (!ntfReady) @(negedge clk);
    ntfValid = 1; ntfSession = sid; ntfLength = len; ntfClosed = cl;
    ntfPeerAddr = addr; ntfPeerPort = port;
    @(posedge clk);
    @(negedge clk);
    ntfValid = 0; ntfClosed = 0;
  endtask

  // full read transaction; keepTotal bytes actually delivered
  task automatic doRead(input logic [15:0] sid, input int len, input int sent, input int bp,
                        input logic [31:0] addr, input logic expErr);
    int nBeats;
    offerNtf(sid, 16'(len), 1'b0, addr, 16'(addr[15:0]));
    chk("R2 reqValid", reqValid, 1);
    chk("R2 reqSession", reqSession, sid);
    chk("R2 reqLength", reqLength, 16'(len));
    chk("R5 ntfReady low", ntfReady, 0);
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      chk("R2 req held", {reqValid, reqSession, reqLength}, {1'b1, sid, 16'(len)});
      chk("R6 no meta yet", metaReady, 0);
    end
    reqReady = 1;
    @(posedge clk);
    @(negedge clk);
    reqReady = 0;
    chk("R6 metaReady", metaReady, 1);
    chk("R7 no data before meta", rxReady | outValid, 0);
    metaValid = 1; metaSession = sid;
    @(posedge clk);
    @(negedge clk);
    metaValid = 0; metaSession = 16'hDEAD;
    chk("R6 metaReady dropped", metaReady, 0);
    nBeats = (sent + KW - 1) / KW;
    for (int b = 0; b < nBeats; b++) begin
      int rem;
      rem = sent - b * KW;
      rxValid = 1;
      rxData = {sid, 16'(len), 16'(b), 16'hA5A5 ^ 16'(bp)};
      rxKeep = (rem >= KW) ? {KW{1'b1}} : KW'((1 << rem) - 1);
      rxLast = (b == nBeats - 1);
      outReady = !((bp == 1) || (bp == 2 && b[0]));
      #1;
      chk("R7 outValid", outValid, 1);
      chk("R7 rxReady", rxReady, outReady);
      chk("R7 data", outData, rxData);
      chk("R7 keep/last", {outKeep, outLast}, {rxKeep, rxLast});
      chk("R6 tag", outSession, sid);
      if (!outReady) begin
        @(negedge clk);
        chk("R5 waiting", ntfReady, 0);
        outReady = 1;
        #1;
        chk("R7 rxReady follows", rxReady, 1);
      end
      @(posedge clk);
      @(negedge clk);
    end
    rxValid = 0; rxLast = 0; outReady = 0;
    chk("R5 ntfReady back", ntfReady, 1);
    chk("R7 idle outValid", outValid, 0);
    chk("R8 errSticky", errSticky, expErr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ntfReady", ntfReady, 1);
    chk("R1 outputs low", {reqValid, metaReady, rxReady, outValid, closeValid, errSticky}, 0);
    rstN = 1;
    @(negedge clk);

    // R3 closed notifications, with and without length
    for (int l = 0; l < 3; l++) begin
      offerNtf(16'h100 + 16'(l), 16'(l * 7), 1'b1, 32'h0A000001, 16'd80);
      chk("R3 closeValid", closeValid, 1);
      chk("R3 closeSession", closeSession, 16'h100 + 16'(l));
      chk("R3 no request", reqValid, 0);
      @(negedge clk);
      chk("R3 single cycle", closeValid, 0);
    end

    // R4 zero-length data notification dropped
    offerNtf(16'h0042, 16'd0, 1'b0, 32'h0, 16'd0);
    chk("R4 no request", reqValid, 0);
    chk("R4 no close", closeValid, 0);
    chk("R4 ntfReady", ntfReady, 1);

    // sweep of lengths and backpressure; peer fields vary (R9)
    for (int bp = 0; bp < 3; bp++)
      for (int len = 1; len <= 24; len++)
        doRead(16'(len * 3 + bp), len, len, bp, 32'(len * 32'h01010101 + bp), 1'b0);

    // R9 same transaction with different peer identity behaves identically
    doRead(16'h7777, 9, 9, 0, 32'hFFFFFFFF, 1'b0);
    doRead(16'h7777, 9, 9, 0, 32'h00000000, 1'b0);

    // R8 mismatch: 10 requested, 12 delivered
    doRead(16'h0BAD, 10, 12, 0, 32'h1, 1'b1);
    // R8 stays set after a clean transfer
    doRead(16'h0600, 8, 8, 1, 32'h2, 1'b1);

    finishRun();
  end
endmodule